// File: doc/BRIEF.md
# Sequential Signed/Unsigned Long-by-Half Divider

The block divides a double-width dividend (32 bits by default) by a half-width divisor (16 bits by default) over a series of clock cycles, treating both operands either as unsigned binary or as two's-complement numbers according to a mode select sampled with the start pulse. A completed division returns one double-width word with the remainder in the upper half and the quotient in the lower half. Alongside the word it returns negative, zero, overflow, carry and extend condition flags, and it flags a zero divisor.

A client raises `start` for one cycle while the block is idle. The block then reports `busy` and later pulses `done` for one cycle, with the new result and flags. Those outputs hold until the next completion. A zero divisor, or a dividend so large that the quotient magnitude cannot fit in half a word, ends the operation after a single check cycle. In that case the original dividend is returned untouched. All other divisions run one restoring step per quotient bit and then one sign-fixing cycle.

Top module: `wide_divider`

## Requirements
- R1: In unsigned mode (`signedMode`=0), a completed division with a nonzero divisor and a quotient below 2^HALF_W sets `result[HALF_W-1:0]` to the quotient and `result[2*HALF_W-1:HALF_W]` to the remainder, and clears `flagV`.
- R2: In signed mode (`signedMode`=1), the quotient truncates toward zero and the remainder carries the sign of the dividend, both packed as in R1 in two's complement. A quotient is accepted when it lies in [-2^(HALF_W-1), 2^(HALF_W-1)-1].
- R3: When the quotient does not fit (as defined in R1 and R2) and the divisor is nonzero, `flagV` is 1, `divZero` is 0 and `result` equals the dividend presented with `start`.
- R4: When the division succeeds, `flagN` equals bit HALF_W-1 of the packed quotient, `flagZ` is 1 exactly when the quotient is zero, and `flagV` is 0.
- R5: On every completion `flagC` is 0 and `flagX` equals the `xIn` value sampled with `start`.
- R6: A zero divisor makes `divZero` and `done` high together for one cycle, with `flagV` 0 and `result` equal to the dividend.
- R7: Counting the edge that samples `start` as edge 1, `done` rises on edge 2 when the divisor is zero or when the magnitude quotient |dividend|/|divisor| is at least 2^HALF_W. Otherwise it rises on edge HALF_W+3.
- R8: `busy` is 0 after reset and 1 from the edge after `start` until the edge that raises `done`. A `start` seen while `busy` is 1 is ignored. A `start` in the cycle where `done` is high is accepted.
- R9: `done` and `divZero` are single-cycle pulses. `result` and the flags change only on the edge that raises `done`, and they reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a division |
| signedMode | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend | input | 2*HALF_W | Dividend, sampled with start |
| divisor | input | HALF_W | Divisor, sampled with start |
| xIn | input | 1 | Current extend flag, reported back unchanged |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2*HALF_W | Remainder in the upper half, quotient in the lower half |
| flagN | output | 1 | Quotient negative |
| flagZ | output | 1 | Quotient zero |
| flagV | output | 1 | Quotient overflow |
| flagC | output | 1 | Carry, always clear |
| flagX | output | 1 | Extend, copy of xIn |
| divZero | output | 1 | One-cycle pulse on zero divisor |

## Verification
Two events can share a cycle: the completion of one division and the acceptance of the next. Every sweep request is issued in the very cycle that `done` is seen, so each new operation is captured while the previous result is being presented. Each operation is judged on its own packed value, flags and edge count against an integer model.

A second pair that can coincide is an ignored `start` arriving mid-operation. It is provoked on the full-width instance with different operands. The check confirms that the original division's result and latency are unchanged.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ITER,
    ST_FIX
  } divState_t;

  typedef struct packed {
    logic load;
    logic eval;
    logic step;
    logic fix;
  } divStrobe_t;

endpackage

// File: rtl/wdiv_ctrl.sv
module wdiv_ctrl
  import wdiv_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       earlyExit,
  output divStrobe_t strb,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = (HALF_W > 1) ? $clog2(HALF_W) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(HALF_W - 1);

  divState_t state, stateNext;
  logic [CNT_W-1:0] stepCnt;
  logic finishing;

  always_comb begin
    strb      = '0;
    stateNext = state;
    finishing = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stateNext = ST_CHECK;
        end
      end
      ST_CHECK: begin
        strb.eval = 1'b1;
        if (earlyExit) begin
          stateNext = ST_IDLE;
          finishing = 1'b1;
        end else begin
          stateNext = ST_ITER;
        end
      end
      ST_ITER: begin
        strb.step = 1'b1;
        if (stepCnt == LAST_STEP) stateNext = ST_FIX;
      end
      ST_FIX: begin
        strb.fix  = 1'b1;
        finishing = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= finishing;
      if (strb.eval)      stepCnt <= '0;
      else if (strb.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/wdiv_datapath.sv
module wdiv_datapath
  import wdiv_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  divStrobe_t            strb,
  input  logic                  signedMode,
  input  logic [2*HALF_W-1:0]   dividend,
  input  logic [HALF_W-1:0]     divisor,
  input  logic                  xIn,
  output logic                  earlyExit,
  output logic [2*HALF_W-1:0]   result,
  output logic                  flagN,
  output logic                  flagZ,
  output logic                  flagV,
  output logic                  flagC,
  output logic                  flagX,
  output logic                  divZero
);

  localparam int FULL_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] MIN_MAG = {1'b1, {(HALF_W-1){1'b0}}};

  // captured operands
  logic [FULL_W-1:0] origA;
  logic [FULL_W-1:0] magA;
  logic [HALF_W-1:0] magB;
  logic              negA, negB, isSigned, xHold;

  // iteration state
  logic [HALF_W-1:0] remReg;
  logic [HALF_W-1:0] quoReg;

  logic              divisorIsZero, magTooBig;
  logic [HALF_W:0]   shifted, trial;
  logic              trialFits;
  logic              negQ, signedOvf;
  logic [HALF_W-1:0] qOut, rOut;

  assign divisorIsZero = (magB == '0);
  assign magTooBig     = (magA[FULL_W-1:HALF_W] >= magB);
  assign earlyExit     = divisorIsZero | magTooBig;

  // one restoring step
  assign shifted   = {remReg, quoReg[HALF_W-1]};
  assign trial     = shifted - {1'b0, magB};
  assign trialFits = ~trial[HALF_W];

  // sign correction
  assign negQ      = negA ^ negB;
  assign signedOvf = isSigned & (negQ ? (quoReg > MIN_MAG) : quoReg[HALF_W-1]);
  assign qOut      = negQ ? (HALF_W'(0) - quoReg) : quoReg;
  assign rOut      = negA ? (HALF_W'(0) - remReg) : remReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      origA    <= '0;
      magA     <= '0;
      magB     <= '0;
      negA     <= 1'b0;
      negB     <= 1'b0;
      isSigned <= 1'b0;
      xHold    <= 1'b0;
    end else if (strb.load) begin
      origA    <= dividend;
      isSigned <= signedMode;
      xHold    <= xIn;
      negA     <= signedMode & dividend[FULL_W-1];
      negB     <= signedMode & divisor[HALF_W-1];
      magA     <= (signedMode & dividend[FULL_W-1]) ? (FULL_W'(0) - dividend) : dividend;
      magB     <= (signedMode & divisor[HALF_W-1]) ? (HALF_W'(0) - divisor) : divisor;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg <= '0;
      quoReg <= '0;
    end else if (strb.eval) begin
      remReg <= magA[FULL_W-1:HALF_W];
      quoReg <= magA[HALF_W-1:0];
    end else if (strb.step) begin
      remReg <= trialFits ? trial[HALF_W-1:0] : shifted[HALF_W-1:0];
      quoReg <= {quoReg[HALF_W-2:0], trialFits};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result  <= '0;
      flagN   <= 1'b0;
      flagZ   <= 1'b0;
      flagV   <= 1'b0;
      flagC   <= 1'b0;
      flagX   <= 1'b0;
      divZero <= 1'b0;
    end else begin
      divZero <= 1'b0;
      if (strb.eval && earlyExit) begin
        result  <= origA;
        flagN   <= 1'b0;
        flagZ   <= 1'b0;
        flagV   <= ~divisorIsZero;
        flagC   <= 1'b0;
        flagX   <= xHold;
        divZero <= divisorIsZero;
      end else if (strb.fix) begin
        flagC <= 1'b0;
        flagX <= xHold;
        if (signedOvf) begin
          result <= origA;
          flagN  <= 1'b0;
          flagZ  <= 1'b0;
          flagV  <= 1'b1;
        end else begin
          result <= {rOut, qOut};
          flagN  <= qOut[HALF_W-1];
          flagZ  <= (qOut == '0);
          flagV  <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/wide_divider.sv
module wide_divider
  import wdiv_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                signedMode,
  input  logic [2*HALF_W-1:0] dividend,
  input  logic [HALF_W-1:0]   divisor,
  input  logic                xIn,
  output logic                busy,
  output logic                done,
  output logic [2*HALF_W-1:0] result,
  output logic                flagN,
  output logic                flagZ,
  output logic                flagV,
  output logic                flagC,
  output logic                flagX,
  output logic                divZero
);

  divStrobe_t strb;
  logic       earlyExit;

  wdiv_ctrl #(.HALF_W(HALF_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .earlyExit (earlyExit),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  wdiv_datapath #(.HALF_W(HALF_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .signedMode (signedMode),
    .dividend   (dividend),
    .divisor    (divisor),
    .xIn        (xIn),
    .earlyExit  (earlyExit),
    .result     (result),
    .flagN      (flagN),
    .flagZ      (flagZ),
    .flagV      (flagV),
    .flagC      (flagC),
    .flagX      (flagX),
    .divZero    (divZero)
  );

endmodule

// File: rtl/wide_divider_chk.sv
module wide_divider_chk #(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic [2*HALF_W-1:0] result,
  input logic                flagV,
  input logic                flagC,
  input logic                flagX,
  input logic                divZero
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R9
  AST_DZ_PULSE: assert property (@(posedge clk) disable iff (!rstN) divZero |=> !divZero); // R9
  AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rstN) done |-> !flagC); // R5
  AST_DZ_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN) divZero |-> (done && !flagV)); // R6
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rstN) (start && !busy) |=> busy); // R8
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN) !done |-> $stable(result)); // R9
  AST_EXTEND_HELD: assert property (@(posedge clk) disable iff (!rstN) !done |-> $stable(flagX)); // R5

endmodule

bind wide_divider wide_divider_chk #(.HALF_W(HALF_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .result  (result),
  .flagV   (flagV),
  .flagC   (flagC),
  .flagX   (flagX),
  .divZero (divZero)
);

// File: tb/tb_wide_divider.sv
module tb_wide_divider;

  localparam int SH = 4;
  localparam int BH = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // small instance
  logic sStart = 0, sSigned = 0, sX = 0;
  logic [2*SH-1:0] sA = '0;
  logic [SH-1:0] sB = '0;
  logic sBusy, sDone, sN, sZ, sV, sC, sXo, sDz;
  logic [2*SH-1:0] sRes;

  wide_divider #(.HALF_W(SH)) dut (
    .clk(clk), .rstN(rstN), .start(sStart), .signedMode(sSigned),
    .dividend(sA), .divisor(sB), .xIn(sX), .busy(sBusy), .done(sDone),
    .result(sRes), .flagN(sN), .flagZ(sZ), .flagV(sV), .flagC(sC),
    .flagX(sXo), .divZero(sDz)
  );

  // full-width instance
  logic bStart = 0, bSigned = 0, bX = 0;
  logic [2*BH-1:0] bA = '0;
  logic [BH-1:0] bB = '0;
  logic bBusy, bDone, bN, bZ, bV, bC, bXo, bDz;
  logic [2*BH-1:0] bRes;

  wide_divider #(.HALF_W(BH)) bigDut (
    .clk(clk), .rstN(rstN), .start(bStart), .signedMode(bSigned),
    .dividend(bA), .divisor(bB), .xIn(bX), .busy(bBusy), .done(bDone),
    .result(bRes), .flagN(bN), .flagZ(bZ), .flagV(bV), .flagC(bC),
    .flagX(bXo), .divZero(bDz)
  );

  task automatic check(input string tag, input bit ok, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent arithmetic model; h is the half width
  task automatic judge(input int h, input bit sgn, input longint unsigned aRaw,
                       input longint unsigned bRaw, input bit xv,
                       input longint unsigned gRes, input bit gN, input bit gZ,
                       input bit gV, input bit gC, input bit gX, input bit gDz,
                       input int gLat);
    longint a, b, q, r, ma, mb;
    longint unsigned mask, expRes;
    bit ovf, dz, early;
    int lat;
    string tag;
    mask = (64'd1 << h) - 1;
    a = longint'(aRaw);
    b = longint'(bRaw);
    if (sgn) begin
      if (aRaw[2*h-1]) a = a - (longint'(1) << (2*h));
      if (bRaw[h-1])   b = b - (longint'(1) << h);
    end
    dz = (b == 0);
    ovf = 0;
    q = 0;
    r = 0;
    early = dz;
    if (!dz) begin
      q = a / b;
      r = a % b;
      ma = (a < 0) ? -a : a;
      mb = (b < 0) ? -b : b;
      early = (ma / mb) >= (longint'(1) << h);
      if (sgn) ovf = (q < -(longint'(1) << (h-1))) || (q > (longint'(1) << (h-1)) - 1);
      else     ovf = (q > longint'(mask));
    end
    lat = early ? 2 : h + 3;
    if (dz || ovf) expRes = aRaw;
    else expRes = ((longint'(r) & mask) << h) | (longint'(q) & mask);

    if (dz) tag = "R6";
    else if (ovf) tag = "R3";
    else if (sgn) tag = "R2";
    else tag = "R1";
    check({tag, " result"}, gRes == expRes && gV == (ovf && !dz) && gDz == dz,
          gRes, expRes);
    if (!dz && !ovf)
      check("R4 flags NZ", gN == expRes[h-1] && gZ == ((expRes & mask) == 0),
            {gN, gZ}, {expRes[h-1], (expRes & mask) == 0});
    check("R5 flags CX", gC == 0 && gX == xv, {gC, gX}, {1'b0, xv});
    check("R7 latency", gLat == lat, gLat, lat);
  endtask

  // small op: call at a negedge; returns at the negedge where done is seen
  task automatic opSmall(input bit sgn, input int a, input int b, input bit xv);
    int n;
    sSigned = sgn; sA = a[2*SH-1:0]; sB = b[SH-1:0]; sX = xv; sStart = 1;
    @(posedge clk);
    @(negedge clk);
    sStart = 0;
    n = 1;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (sDone || n > 100) break;
    end
    judge(SH, sgn, longint'(a) & 8'hFF, longint'(b) & 4'hF, xv,
          sRes, sN, sZ, sV, sC, sXo, sDz, n);
  endtask

  // big op, with optional mid-run intruding start
  task automatic opBig(input bit sgn, input longint unsigned a, input longint unsigned b,
                       input bit xv, input bit intrude);
    int n;
    bSigned = sgn; bA = a[31:0]; bB = b[15:0]; bX = xv; bStart = 1;
    @(posedge clk);
    @(negedge clk);
    bStart = 0;
    n = 1;
    while (1) begin
      if (intrude && n == 4) begin
        bStart = 1; bA = 32'h0000_0009; bB = 16'h0002; bSigned = ~sgn; bX = ~xv;
      end else begin
        bStart = 0;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
      if (intrude && n == 5) check("R8 busy during run", bBusy == 1, bBusy, 1);
      if (bDone || n > 100) break;
    end
    bStart = 0;
    judge(BH, sgn, a, b, xv, bRes, bN, bZ, bV, bC, bXo, bDz, n);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2*BH-1:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    check("R9 reset outputs", sDone == 0 && sRes == 0 && sDz == 0 && bRes == 0,
          {sDone, sRes}, 0);
    check("R8 reset busy", sBusy == 0 && bBusy == 0, {sBusy, bBusy}, 0);

    // exhaustive sweep of the small configuration, back-to-back requests
    for (int sg = 0; sg < 2; sg++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 16; b++)
          opSmall(sg[0], a, b, a[0] ^ b[1]);

    // full-width directed cases
    opBig(0, 64'h0001_0000, 64'h0002, 1, 0);   // R1 quotient 0x8000 fits
    opBig(1, 64'h0001_0000, 64'h0002, 0, 0);   // R3 late signed overflow
    opBig(1, 64'hFFFF_FFF9, 64'h0002, 1, 0);   // R2 -7/2
    opBig(1, 64'h0000_0007, 64'hFFFE, 0, 0);   // R2 7/-2
    opBig(1, 64'h8000_0000, 64'hFFFF, 1, 0);   // R3 early overflow
    opBig(0, 64'hFFFF_FFFF, 64'hFFFF, 0, 0);   // R3 unsigned overflow
    opBig(0, 64'h1234_5678, 64'h0000, 1, 0);   // R6 zero divisor
    opBig(1, 64'hFFFF_8000, 64'h0001, 0, 0);   // R2 most negative quotient
    opBig(0, 64'h0000_0000, 64'h1234, 1, 0);   // R4 zero quotient
    opBig(0, 64'h0012_3456, 64'h0100, 0, 1);   // R8 intruding start ignored

    // R9: pulses drop and result is held after completion
    opBig(1, 64'hFFFF_FF00, 64'h0000, 1, 0);
    held = bRes;
    @(posedge clk);
    @(negedge clk);
    check("R9 done pulse", bDone == 0 && bDz == 0, {bDone, bDz}, 0);
    check("R9 result held", bRes == held, bRes, held);
    check("R8 idle after done", bBusy == 0, bBusy, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule